// File: doc/BRIEF.md
# Dual-Load Banked L1 Data Cache Read Path

This block is the load side of a 32 KiB first-level data cache: 8 ways, 64-byte lines and 64 sets. Two load requests may arrive in one cycle. Each request carries:

- a virtual address, whose page-offset bits pick the set;
- a byte count of 1 to 16;
- the physical tag of the line that holds its first byte;
- a second physical tag, used when the access runs past the end of that line into the next one.

For every lookup the tags and data of all eight ways of a set are read together. The way whose tag matches then steers its line to the output. The requested bytes are rotated down so that the first byte lands in byte 0. When an access crosses a line boundary, the block reads two neighbouring sets and joins the two fragments. Address translation is not part of the block; the caller supplies the physical tags.

Data storage is divided into eight 16-byte banks. Address bits [6:4] name the bank, so one line occupies four banks and the next line the other four. When both loads touch a bank for two different lines, they collide. In that case load 0 is served and load 1 is flagged for replay. Results appear one clock after the request, with per-load hit and replay flags. A simple line-install port fills tags and data so the array can be brought into a known state; refill policy is not part of the block.

Top module: `l1rd_top`

## Requirements
- R1: The set index is reqVaddr[11:6], giving 64 sets. A lookup hits only in a way that was installed with the same 24-bit physical tag through the install port (instSet, instWay, instTag, instLine, where instLine byte i is line byte i).
- R2: On a hit, rspData byte k equals line byte (reqVaddr[5:0]+k) for every k not larger than reqSizeM1 (byte count minus one). All higher bytes of rspData are zero.
- R3: All eight ways of a set are compared in the same lookup, and a line installed in any way 0 to 7 is returned.
- R4: When no valid way matches the tag, rspHit is 0 and rspData is zero.
- R5: An access of 1 to 16 bytes at any offset that ends inside its 64-byte line completes in the same single cycle as an aligned one.
- R6: When reqVaddr[5:0]+reqSizeM1 exceeds 63, bytes past the line end come from set index+1, wrapping from 63 to 0, matched against reqPtagHi. The two fragments are joined into one result.
- R7: A line-crossing access reports a miss if either of its two lines misses.
- R8: Bank = {set bit 0, reqVaddr[5:4]}. When both loads are valid and touch a common bank for different lines (different set or different tag), load 1 gets rspReplay=1, rspHit=0 and zero data, while load 0 completes normally.
- R9: Two loads that share banks only within the same line, or that touch disjoint banks, are both served with no replay.
- R10: After reset, rspValid, rspHit and rspReplay are 0 and every way is invalid, so lookups miss until lines are installed.
- R11: rspValid, rspHit, rspReplay and rspData for a load appear exactly one clock after reqValid is sampled. An idle slot gives rspValid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 2 | Load valid per slot |
| reqVaddr | input | 2x12 | Virtual address page offset per slot |
| reqSizeM1 | input | 2x4 | Byte count minus one per slot |
| reqPtagLo | input | 2x24 | Physical tag of the first line |
| reqPtagHi | input | 2x24 | Physical tag of the following line (line-crossing only) |
| instValid | input | 1 | Install a line this cycle |
| instSet | input | 6 | Set to install into |
| instWay | input | 3 | Way to install into |
| instTag | input | 24 | Physical tag to install |
| instLine | input | 512 | Line data, byte i in bits [8i+7:8i] |
| rspValid | output | 2 | Response valid per slot |
| rspHit | output | 2 | Hit per slot |
| rspReplay | output | 2 | Replay request per slot |
| rspData | output | 2x128 | Rotated, zero-padded load data |

## Verification
The checks assume that the install port never places the same tag in two ways of one set, because a duplicate would make two ways match at once. The bench gives each way of a set its own tag. The checks also assume that a response is judged only in the cycle after its request. Probes therefore use tags that were never installed to create misses, and they drive line-crossing, same-line and colliding pairs on chosen sets and offsets.

// File: rtl/l1rd_pkg.sv
package l1rd_pkg;
  parameter int SETS = 64;
  parameter int WAYS = 8;
  parameter int LINE_BYTES = 64;
  parameter int CHUNK_BYTES = 16;
  parameter int PTAG_W = 24;
  parameter int VA_W = 12;

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CHUNKS = LINE_BYTES / CHUNK_BYTES;
  localparam int CIDX_W = $clog2(CHUNKS);
  localparam int CIDX_LSB = OFF_W - CIDX_W;
  localparam int BANKS = 2 * CHUNKS;
  localparam int SIZE_W = $clog2(CHUNK_BYTES);
  localparam int CHUNK_W = CHUNK_BYTES * 8;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int ENTRIES = SETS * WAYS;

  typedef struct packed {
    logic lookup;
    logic split;
    logic replay;
  } strobe_t;
endpackage

// File: rtl/l1rd_ctrl.sv
module l1rd_ctrl
  import l1rd_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [1:0]                  reqValid,
  input  logic [1:0][VA_W-1:0]        reqVaddr,
  input  logic [1:0][SIZE_W-1:0]      reqSizeM1,
  input  logic [1:0][PTAG_W-1:0]      reqPtagLo,
  input  logic [1:0][PTAG_W-1:0]      reqPtagHi,
  output strobe_t [1:0]               strobe
);
  logic [1:0][OFF_W:0]                lastOff;
  logic [1:0]                         split;
  logic [1:0][SET_W-1:0]              setLo;
  logic [1:0][SET_W-1:0]              setHi;
  logic [1:0][CIDX_W-1:0]             firstChunk;
  logic [1:0][CIDX_W-1:0]             lastChunk;
  logic [1:0][BANKS-1:0]              touch;
  logic [1:0][BANKS-1:0][SET_W-1:0]   bankSet;
  logic [1:0][BANKS-1:0][PTAG_W-1:0]  bankTag;
  logic [BANKS-1:0]                   clash;
  logic                               conflict;

  always_comb begin
    for (int r = 0; r < 2; r++) begin
      lastOff[r]    = {1'b0, reqVaddr[r][OFF_W-1:0]} + (OFF_W+1)'(reqSizeM1[r]);
      split[r]      = lastOff[r][OFF_W];
      setLo[r]      = reqVaddr[r][OFF_W+SET_W-1:OFF_W];
      setHi[r]      = setLo[r] + 1'b1;
      firstChunk[r] = reqVaddr[r][OFF_W-1:CIDX_LSB];
      lastChunk[r]  = lastOff[r][OFF_W-1:CIDX_LSB];
      for (int b = 0; b < BANKS; b++) begin
        if ((b / CHUNKS) == int'(setLo[r][0])) begin
          touch[r][b]   = ((b % CHUNKS) >= int'(firstChunk[r])) &&
                          (split[r] || ((b % CHUNKS) <= int'(lastChunk[r])));
          bankSet[r][b] = setLo[r];
          bankTag[r][b] = reqPtagLo[r];
        end else begin
          touch[r][b]   = split[r] && ((b % CHUNKS) <= int'(lastChunk[r]));
          bankSet[r][b] = setHi[r];
          bankTag[r][b] = reqPtagHi[r];
        end
      end
    end
    for (int b = 0; b < BANKS; b++) begin
      clash[b] = touch[0][b] && touch[1][b] &&
                 ((bankSet[0][b] != bankSet[1][b]) || (bankTag[0][b] != bankTag[1][b]));
    end
    conflict = (&reqValid) && (|clash);
  end

  always_comb begin
    strobe[0].lookup = reqValid[0];
    strobe[0].split  = split[0];
    strobe[0].replay = 1'b0;
    strobe[1].lookup = reqValid[1] && !conflict;
    strobe[1].split  = split[1];
    strobe[1].replay = reqValid[1] && conflict;
  end

  AST_SAME_LINE_SERVED: assert property (@(posedge clk) disable iff (!rstN)
    ((&reqValid) && !split[0] && !split[1] &&
     (reqVaddr[0][VA_W-1:OFF_W] == reqVaddr[1][VA_W-1:OFF_W]) &&
     (reqPtagLo[0] == reqPtagLo[1])) |-> (strobe[1].lookup && !strobe[1].replay)); // R9

  AST_SLOT0_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid[0] |-> strobe[0].lookup); // R8
endmodule

// File: rtl/l1rd_datapath.sv
module l1rd_datapath
  import l1rd_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [1:0]                  reqValid,
  input  logic [1:0][VA_W-1:0]        reqVaddr,
  input  logic [1:0][SIZE_W-1:0]      reqSizeM1,
  input  logic [1:0][PTAG_W-1:0]      reqPtagLo,
  input  logic [1:0][PTAG_W-1:0]      reqPtagHi,
  input  strobe_t [1:0]               strobe,
  input  logic                        instValid,
  input  logic [SET_W-1:0]            instSet,
  input  logic [WAY_W-1:0]            instWay,
  input  logic [PTAG_W-1:0]           instTag,
  input  logic [LINE_W-1:0]           instLine,
  output logic [1:0]                  rspValid,
  output logic [1:0]                  rspHit,
  output logic [1:0]                  rspReplay,
  output logic [1:0][CHUNK_W-1:0]     rspData
);
  logic [LINE_W-1:0] lineMem [ENTRIES];
  logic [PTAG_W-1:0] tagMem  [ENTRIES];
  logic [ENTRIES-1:0] validMem;

  always_ff @(posedge clk) begin
    if (instValid) begin
      lineMem[{instSet, instWay}] <= instLine;
      tagMem[{instSet, instWay}]  <= instTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) validMem <= '0;
    else if (instValid) validMem[{instSet, instWay}] <= 1'b1;
  end

  for (genvar gr = 0; gr < 2; gr++) begin : gSlot
    logic [SET_W-1:0]    sLo, sHi;
    logic [WAYS-1:0]     matchLo, matchHi;
    logic [LINE_W-1:0]   lineLo, lineHi;
    logic [2*LINE_W-1:0] shifted;
    logic [CHUNK_W-1:0]  bytesOut;
    logic                hitAll;

    always_comb begin
      sLo    = reqVaddr[gr][OFF_W+SET_W-1:OFF_W];
      sHi    = sLo + 1'b1;
      lineLo = '0;
      lineHi = '0;
      for (int w = 0; w < WAYS; w++) begin
        matchLo[w] = validMem[{sLo, WAY_W'(w)}] && (tagMem[{sLo, WAY_W'(w)}] == reqPtagLo[gr]);
        matchHi[w] = validMem[{sHi, WAY_W'(w)}] && (tagMem[{sHi, WAY_W'(w)}] == reqPtagHi[gr]);
        if (matchLo[w]) lineLo = lineLo | lineMem[{sLo, WAY_W'(w)}];
        if (matchHi[w]) lineHi = lineHi | lineMem[{sHi, WAY_W'(w)}];
      end
      shifted = {lineHi, lineLo} >> {reqVaddr[gr][OFF_W-1:0], 3'b000};
      for (int k = 0; k < CHUNK_BYTES; k++) begin
        bytesOut[k*8 +: 8] = (k <= int'(reqSizeM1[gr])) ? shifted[k*8 +: 8] : 8'h00;
      end
      hitAll = strobe[gr].lookup && (|matchLo) && (!strobe[gr].split || (|matchHi));
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rspValid[gr]  <= 1'b0;
        rspHit[gr]    <= 1'b0;
        rspReplay[gr] <= 1'b0;
        rspData[gr]   <= '0;
      end else begin
        rspValid[gr]  <= reqValid[gr];
        rspHit[gr]    <= hitAll;
        rspReplay[gr] <= strobe[gr].replay;
        rspData[gr]   <= hitAll ? bytesOut : '0;
      end
    end

    AST_WAY_ONEHOT_LO: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(matchLo)); // R3
    AST_WAY_ONEHOT_HI: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(matchHi)); // R6
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
      reqValid[gr] |=> rspValid[gr]); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      !reqValid[gr] |=> (!rspValid[gr] && !rspHit[gr] && !rspReplay[gr])); // R11
    AST_REPLAY_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
      rspReplay[gr] |-> (!rspHit[gr] && rspData[gr] == '0)); // R8
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !rspHit[gr] |-> (rspData[gr] == '0)); // R4
  end

  AST_REPLAY_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    rspReplay[1] |-> (rspValid[0] && !rspReplay[0])); // R8
endmodule

// File: rtl/l1rd_top.sv
module l1rd_top
  import l1rd_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [1:0]                  reqValid,
  input  logic [1:0][VA_W-1:0]        reqVaddr,
  input  logic [1:0][SIZE_W-1:0]      reqSizeM1,
  input  logic [1:0][PTAG_W-1:0]      reqPtagLo,
  input  logic [1:0][PTAG_W-1:0]      reqPtagHi,
  input  logic                        instValid,
  input  logic [SET_W-1:0]            instSet,
  input  logic [WAY_W-1:0]            instWay,
  input  logic [PTAG_W-1:0]           instTag,
  input  logic [LINE_W-1:0]           instLine,
  output logic [1:0]                  rspValid,
  output logic [1:0]                  rspHit,
  output logic [1:0]                  rspReplay,
  output logic [1:0][CHUNK_W-1:0]     rspData
);
  strobe_t [1:0] strobe;

  l1rd_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqVaddr  (reqVaddr),
    .reqSizeM1 (reqSizeM1),
    .reqPtagLo (reqPtagLo),
    .reqPtagHi (reqPtagHi),
    .strobe    (strobe)
  );

  l1rd_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqVaddr  (reqVaddr),
    .reqSizeM1 (reqSizeM1),
    .reqPtagLo (reqPtagLo),
    .reqPtagHi (reqPtagHi),
    .strobe    (strobe),
    .instValid (instValid),
    .instSet   (instSet),
    .instWay   (instWay),
    .instTag   (instTag),
    .instLine  (instLine),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspReplay (rspReplay),
    .rspData   (rspData)
  );
endmodule

// File: tb/sim_l1rd_top.sv
module sim_l1rd_top;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        reqValid = '0;
  logic [1:0][11:0]  reqVaddr = '0;
  logic [1:0][3:0]   reqSizeM1 = '0;
  logic [1:0][23:0]  reqPtagLo = '0;
  logic [1:0][23:0]  reqPtagHi = '0;
  logic              instValid = 1'b0;
  logic [5:0]        instSet = '0;
  logic [2:0]        instWay = '0;
  logic [23:0]       instTag = '0;
  logic [511:0]      instLine = '0;
  logic [1:0]        rspValid, rspHit, rspReplay;
  logic [1:0][127:0] rspData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  localparam logic [23:0] BAD_TAG = 24'h000BAD;

  always #(CLK_PERIOD/2) clk = ~clk;

  l1rd_top u0 (.*);

  function automatic logic [7:0] lineByte(int s, int w, int i);
    return 8'((s * 5 + w * 37 + i * 11 + 3) & 255);
  endfunction

  function automatic logic [23:0] tagOf(int w);
    return 24'h00A000 + 24'(w);
  endfunction

  function automatic logic [127:0] expData(int s, int off, int sz, int wLo, int wHi);
    logic [127:0] d = '0;
    for (int k = 0; k < 16; k++) begin
      if (k <= sz) begin
        if (off + k < 64) d[k*8 +: 8] = lineByte(s, wLo, off + k);
        else              d[k*8 +: 8] = lineByte((s + 1) % 64, wHi, off + k - 64);
      end
    end
    return d;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setReq(int r, int s, int off, int sz, logic [23:0] tLo, logic [23:0] tHi);
    reqValid[r]  = 1'b1;
    reqVaddr[r]  = 12'(s * 64 + off);
    reqSizeM1[r] = 4'(sz);
    reqPtagLo[r] = tLo;
    reqPtagHi[r] = tHi;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    reqValid = '0;
  endtask

  task automatic tReset();
    chk(rspValid == 2'b00 && rspHit == 2'b00 && rspReplay == 2'b00, "R10 outputs",
        {122'b0, rspValid, rspHit, rspReplay}, 128'h0);
    setReq(0, 3, 0, 15, tagOf(0), tagOf(0));
    cycle();
    chk(rspValid[0] && !rspHit[0], "R10 empty cache misses", {126'b0, rspValid[0], rspHit[0]}, 128'h2);
  endtask

  task automatic installAll();
    for (int s = 0; s < 64; s++) begin
      for (int w = 0; w < 8; w++) begin
        instValid = 1'b1;
        instSet = 6'(s);
        instWay = 3'(w);
        instTag = tagOf(w);
        for (int i = 0; i < 64; i++) instLine[i*8 +: 8] = lineByte(s, w, i);
        @(posedge clk);
        @(negedge clk);
      end
    end
    instValid = 1'b0;
  endtask

  task automatic tAligned();
    setReq(0, 5, 0, 15, tagOf(3), tagOf(0));
    cycle();
    chk(rspValid == 2'b01, "R11 valid one cycle later", {126'b0, rspValid}, 128'h1);
    chk(rspHit[0], "R1 aligned hit", {127'b0, rspHit[0]}, 128'h1);
    chk(rspData[0] == expData(5, 0, 15, 3, 0), "R1 aligned data", rspData[0], expData(5, 0, 15, 3, 0));
  endtask

  task automatic tAllWays();
    for (int w = 0; w < 8; w++) begin
      setReq(0, 9, 16, 7, tagOf(w), tagOf(0));
      cycle();
      chk(rspHit[0] && rspData[0] == expData(9, 16, 7, w, 0), "R3 way select",
          rspData[0], expData(9, 16, 7, w, 0));
    end
  endtask

  task automatic tMiss();
    setReq(1, 20, 8, 15, BAD_TAG, tagOf(0));
    cycle();
    chk(rspValid[1] && !rspHit[1] && rspData[1] == '0, "R4 miss", rspData[1], 128'h0);
  endtask

  task automatic tUnaligned();
    setReq(0, 30, 37, 9, tagOf(4), tagOf(0));
    setReq(1, 31, 63, 0, tagOf(6), tagOf(0));
    cycle();
    chk(rspHit[0] && rspData[0] == expData(30, 37, 9, 4, 0), "R5 unaligned inside line",
        rspData[0], expData(30, 37, 9, 4, 0));
    chk(rspHit[1] && rspData[1] == expData(31, 63, 0, 6, 0), "R2 single last byte",
        rspData[1], expData(31, 63, 0, 6, 0));
  endtask

  task automatic tSplit();
    setReq(0, 12, 58, 15, tagOf(2), tagOf(6));
    cycle();
    chk(rspHit[0] && rspData[0] == expData(12, 58, 15, 2, 6), "R6 line-crossing join",
        rspData[0], expData(12, 58, 15, 2, 6));
    setReq(1, 63, 60, 11, tagOf(1), tagOf(7));
    cycle();
    chk(rspHit[1] && rspData[1] == expData(63, 60, 11, 1, 7), "R6 set wrap 63 to 0",
        rspData[1], expData(63, 60, 11, 1, 7));
  endtask

  task automatic tSplitMiss();
    setReq(0, 40, 50, 15, tagOf(2), BAD_TAG);
    setReq(1, 44, 60, 15, BAD_TAG, tagOf(3));
    cycle();
    chk(rspValid[0] && !rspHit[0], "R7 upper half miss", {127'b0, rspHit[0]}, 128'h0);
    chk(rspValid[1] && !rspHit[1], "R7 lower half miss", {127'b0, rspHit[1]}, 128'h0);
  endtask

  task automatic tConflict();
    setReq(0, 4, 0, 15, tagOf(1), tagOf(0));
    setReq(1, 4, 0, 15, tagOf(2), tagOf(0));
    cycle();
    chk(rspReplay == 2'b10 && !rspHit[1] && rspData[1] == '0, "R8 same set other way",
        {124'b0, rspReplay, rspHit}, {124'b0, 2'b10, 2'b01});
    chk(rspHit[0] && rspData[0] == expData(4, 0, 15, 1, 0), "R8 slot0 served",
        rspData[0], expData(4, 0, 15, 1, 0));
    setReq(0, 6, 16, 3, tagOf(0), tagOf(0));
    setReq(1, 8, 20, 3, tagOf(0), tagOf(0));
    cycle();
    chk(rspReplay == 2'b10 && rspHit == 2'b01, "R8 lines 128 bytes apart",
        {124'b0, rspReplay, rspHit}, {124'b0, 2'b10, 2'b01});
    setReq(0, 10, 60, 7, tagOf(3), tagOf(0));
    setReq(1, 11, 0, 3, tagOf(5), tagOf(0));
    cycle();
    chk(rspReplay == 2'b10 && rspHit == 2'b01, "R8 crossing access collides",
        {124'b0, rspReplay, rspHit}, {124'b0, 2'b10, 2'b01});
  endtask

  task automatic tNoConflict();
    setReq(0, 4, 0, 15, tagOf(1), tagOf(0));
    setReq(1, 4, 8, 15, tagOf(1), tagOf(0));
    cycle();
    chk(rspReplay == 2'b00 && rspHit == 2'b11 && rspData[1] == expData(4, 8, 15, 1, 0),
        "R9 same line shared", rspData[1], expData(4, 8, 15, 1, 0));
    setReq(0, 4, 0, 15, tagOf(1), tagOf(0));
    setReq(1, 4, 32, 15, tagOf(2), tagOf(0));
    cycle();
    chk(rspReplay == 2'b00 && rspHit == 2'b11, "R9 disjoint banks",
        {124'b0, rspReplay, rspHit}, {124'b0, 2'b00, 2'b11});
    setReq(0, 5, 16, 15, tagOf(0), tagOf(0));
    setReq(1, 6, 16, 15, tagOf(0), tagOf(0));
    cycle();
    chk(rspReplay == 2'b00 && rspHit == 2'b11 && rspData[1] == expData(6, 16, 15, 0, 0),
        "R9 adjacent sets other bank half", rspData[1], expData(6, 16, 15, 0, 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    installAll();
    tAligned();
    tAllWays();
    tMiss();
    tUnaligned();
    tSplit();
    tSplitMiss();
    tConflict();
    tNoConflict();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule